// File: doc/BRIEF.md
# Dual-Standard Interlaced Sync Generator

This block derives every raster timing strobe of an interlaced television signal from a single master clock running at 32 ticks per scan line. A mode input selects the line standard: 525 lines per frame (30 frames per second) or 625 lines per frame (25 frames per second). Internally a 16-tick half-line divider, a line-phase bit and a half-line vertical counter do all the timing. Because a field holds an odd number of half-lines, the line phase at which a new field opens alternates from field to field, and the raster interlaces with no separate field counter.

The field opens with a pre-equalizing group, a serrated vertical sync group and a post-equalizing group, each of E half-lines (E = 6 for 525, 5 for 625). Two active-low synchronous preset inputs force the vertical counter either to the opening of the pre-equalizing group or to the opening of the vertical sync group, which lets an external circuit align the vertical phase. All ten outputs are active low and registered.

Top module: `tv_sync_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is high (inactive) after that edge, and the tick, line-phase and half-line counters return to zero.
- R2: Each line is 32 ticks, numbered 0 to 31. `ms_n` carries a horizontal sync low on ticks 0–1 outside the vertical interval. `hd_n` is low on ticks 0–2 and `hc_n` is low on ticks 2–3.
- R3: `hpb_n` is low on ticks 31 and 0–4 (6 ticks). The horizontal part of `mbb_n` covers ticks 30 to 5 (8 ticks). Every tick of horizontal processing blanking is also a tick of beam blanking.
- R4: With `std625` low a field is 525 half-lines; with it high a field is 625 half-lines. The half-line counter advances after each 16th tick and wraps to 0 at the field length, so consecutive fields open alternately at a line start and at mid-line.
- R5: In half-lines v < E and 2E ≤ v < 3E (E = 6 for 525, 5 for 625), `ms_n` is low only on the first tick of each half-line.
- R6: In half-lines E ≤ v < 2E, `ms_n` is low for the first 14 ticks of each half-line (a 2-tick serration ends each one) and `svd_n` is low. `vd_n` is low for all v < 3E.
- R7: `vpb_n` is low for v < 40 (525) or v < 50 (625). `mpb_n` is low when either horizontal or vertical processing blanking is active, and `mbb_n` is low when vertical blanking or horizontal beam blanking is active.
- R8: `fs_n` is low for one tick, on tick 0 of half-line 0, only in a field that opens at a line start (odd field). It then coincides with the first equalizing pulse.
- R9: `eq_pre_n` low at a clock edge sets the half-line counter to 0 (the first pre-equalizing half-line).
- R10: `vs_pre_n` low at a clock edge, with `eq_pre_n` high, sets the half-line counter to E (the first vertical sync half-line).
- R11: When both preset inputs are low, the equalizing preset wins.
- R12: Each output reflects the counter state one clock before: tick 0 after reset appears after the first edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 ticks per line |
| rst_n | input | 1 | Synchronous active-low reset |
| std625 | input | 1 | 1 selects 625-line timing, 0 selects 525-line timing |
| eq_pre_n | input | 1 | Active-low preset to first equalizing half-line |
| vs_pre_n | input | 1 | Active-low preset to first vertical sync half-line |
| hd_n | output | 1 | Horizontal drive |
| vd_n | output | 1 | Vertical drive |
| svd_n | output | 1 | Short vertical drive |
| ms_n | output | 1 | Mixed sync |
| hc_n | output | 1 | Horizontal clamp |
| hpb_n | output | 1 | Horizontal processing blanking |
| vpb_n | output | 1 | Vertical processing blanking |
| mpb_n | output | 1 | Mixed processing blanking |
| mbb_n | output | 1 | Mixed beam blanking |
| fs_n | output | 1 | Odd-field frame pulse |

## Verification
The properties assume that `std625` changes only while `rst_n` is low. A switch from 625 to 525 in mid-field would leave the counter above the new field length until it wraps. The stimulus therefore sets the mode before each reset and holds it afterwards. The preset inputs are asserted only at falling clock edges and held for whole cycles, so each preset lands on a defined edge. The bench relates the output pattern to the half-line position it expects, counting ticks from reset release.

// File: rtl/tv_sync_gen.sv
module tv_sync_gen #(
  parameter int HALF    = 16,
  parameter int N525    = 525,
  parameter int N625    = 625,
  parameter int EQ525   = 6,
  parameter int EQ625   = 5,
  parameter int VB525   = 40,
  parameter int VB625   = 50,
  parameter int HS_W    = 2,
  parameter int HD_W    = 3,
  parameter int CLP_AT  = 2,
  parameter int CLP_W   = 2,
  parameter int HB_W    = 6,
  parameter int EQ_W    = 1,
  parameter int SERR_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic std625,
  input  logic eq_pre_n,
  input  logic vs_pre_n,
  output logic hd_n,
  output logic vd_n,
  output logic svd_n,
  output logic ms_n,
  output logic hc_n,
  output logic hpb_n,
  output logic vpb_n,
  output logic mpb_n,
  output logic mbb_n,
  output logic fs_n
);
  localparam int TW = $clog2(HALF);
  localparam int VW = $clog2(N625 + 1);
  localparam logic [TW-1:0] T_LAST = TW'(HALF - 1);

  logic [TW-1:0] t;
  logic          hb;
  logic [VW-1:0] v;

  logic [VW-1:0] nfield, e1, e2, e3, vbl;
  assign nfield = std625 ? VW'(N625)  : VW'(N525);
  assign e1     = std625 ? VW'(EQ625) : VW'(EQ525);
  assign e2     = e1 + e1;
  assign e3     = e2 + e1;
  assign vbl    = std625 ? VW'(VB625) : VW'(VB525);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t  <= '0;
      hb <= 1'b0;
      v  <= '0;
    end else begin
      t <= (t == T_LAST) ? '0 : t + 1'b1;
      if (t == T_LAST) hb <= ~hb;
      if (!eq_pre_n)        v <= '0;
      else if (!vs_pre_n)   v <= e1;
      else if (t == T_LAST) v <= (v >= nfield - 1'b1) ? '0 : v + 1'b1;
    end
  end

  logic in_eq, in_vs, hs, ms, hd, hc, hpb, bbh, vpb, vd, fs;
  assign in_eq = (v < e1) || (v >= e2 && v < e3);
  assign in_vs = (v >= e1) && (v < e2);
  assign hs    = !hb && t < TW'(HS_W);
  assign ms    = in_eq ? (t < TW'(EQ_W)) : in_vs ? (t < TW'(HALF - SERR_W)) : hs;
  assign hd    = !hb && t < TW'(HD_W);
  assign hc    = !hb && t >= TW'(CLP_AT) && t < TW'(CLP_AT + CLP_W);
  assign hpb   = (hb && t == T_LAST) || (!hb && t < TW'(HB_W - 1));
  assign bbh   = (hb && t >= TW'(HALF - 2)) || (!hb && t < TW'(HB_W));
  assign vpb   = v < vbl;
  assign vd    = v < e3;
  assign fs    = (v == '0) && !hb && (t == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {hd_n, vd_n, svd_n, ms_n, hc_n, hpb_n, vpb_n, mpb_n, mbb_n, fs_n} <= '1;
    end else begin
      hd_n  <= ~hd;
      vd_n  <= ~vd;
      svd_n <= ~in_vs;
      ms_n  <= ~ms;
      hc_n  <= ~hc;
      hpb_n <= ~hpb;
      vpb_n <= ~vpb;
      mpb_n <= ~(hpb | vpb);
      mbb_n <= ~(bbh | vpb);
      fs_n  <= ~fs;
    end
  end

  p_half_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (t == T_LAST) |=> (hb != $past(hb)));
  p_v_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    v < VW'(N625));
  p_eq_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!eq_pre_n) |=> (v == '0));
  p_vs_preset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_pre_n && !vs_pre_n) |=> (v == $past(e1)));
  p_preset_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!eq_pre_n && !vs_pre_n) |=> (v != $past(e1)));
  p_frame_on_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_n) |-> (!ms_n && !hd_n && !vd_n));
  p_svd_in_vd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!svd_n) |-> (!vd_n && !vpb_n));
  p_hpb_in_mbb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hpb_n) |-> (!mbb_n && !mpb_n));
endmodule

// File: tb/tv_sync_gen_test.sv
module tv_sync_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, std625 = 1'b0, eq_pre_n = 1'b1, vs_pre_n = 1'b1;
  logic hd_n, vd_n, svd_n, ms_n, hc_n, hpb_n, vpb_n, mpb_n, mbb_n, fs_n;
  int total = 0, bad = 0, ecount = 0;

  always #5 clk = ~clk;

  tv_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .std625(std625), .eq_pre_n(eq_pre_n), .vs_pre_n(vs_pre_n),
    .hd_n(hd_n), .vd_n(vd_n), .svd_n(svd_n), .ms_n(ms_n), .hc_n(hc_n),
    .hpb_n(hpb_n), .vpb_n(vpb_n), .mpb_n(mpb_n), .mbb_n(mbb_n), .fs_n(fs_n)
  );

  // asserted bits, order: hd vd svd ms hc hpb vpb mpb mbb fs
  logic [9:0] obs;
  assign obs = ~{hd_n, vd_n, svd_n, ms_n, hc_n, hpb_n, vpb_n, mpb_n, mbb_n, fs_n};

  // {mode, tick index since reset, requirement, expected asserted outputs}
  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 16'd0,     4'd8,  10'b1101011111}, // R8 odd field frame pulse
    {1'b0, 16'd2,     4'd2,  10'b1100111110}, // R2 clamp, drive
    {1'b0, 16'd83,    4'd5,  10'b0100001110}, // R5 equalizing gap
    {1'b0, 16'd96,    4'd6,  10'b1111011110}, // R6 vsync start
    {1'b0, 16'd110,   4'd6,  10'b0110001110}, // R6 serration
    {1'b0, 16'd632,   4'd7,  10'b0000001110}, // R7 last blanked half-line
    {1'b0, 16'd640,   4'd7,  10'b1001010110}, // R7 blanking ended
    {1'b0, 16'd645,   4'd3,  10'b0000000010}, // R3 beam blank tail
    {1'b0, 16'd670,   4'd3,  10'b0000000010}, // R3 beam blank head
    {1'b0, 16'd671,   4'd3,  10'b0000010110}, // R3 processing blank head
    {1'b0, 16'd8400,  4'd4,  10'b0101001110}, // R4 even field at mid-line
    {1'b0, 16'd16800, 4'd4,  10'b1101011111}, // R4 next odd field
    {1'b1, 16'd83,    4'd6,  10'b0111001110}, // R6 625 vsync
    {1'b1, 16'd224,   4'd5,  10'b1101011110}, // R5 625 post-eq
    {1'b1, 16'd240,   4'd6,  10'b0000001110}, // R6 625 drive ended
    {1'b1, 16'd792,   4'd7,  10'b0000001110}, // R7 625 blanking
    {1'b1, 16'd800,   4'd7,  10'b1001010110}, // R7 625 blanking ended
    {1'b1, 16'd10000, 4'd4,  10'b0101001110}  // R4 625 field length
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    ecount++;
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    std625 = m;
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    ecount = 0;
  endtask

  task automatic check(input int req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic cur;
    do_reset(1'b0);
    cur = 1'b0;
    check(1, obs, 10'b0); // R1 reset state
    step();
    check(12, obs, 10'b1101011111); // R12 tick 0 after first edge
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][30] != cur || int'(VEC[i][29:14]) + 1 < ecount) begin
        cur = VEC[i][30];
        do_reset(cur);
      end
      while (ecount < int'(VEC[i][29:14]) + 1) step();
      check(int'(VEC[i][13:10]), obs, VEC[i][9:0]);
    end

    // presets, 525 mode
    do_reset(1'b0);
    while (ecount < 200) step();
    vs_pre_n = 1'b0;
    step(); step();
    check(10, {~svd_n, ~vd_n}, 2'b11);   // R10 sync group
    eq_pre_n = 1'b0;
    step(); step();
    check(11, {~svd_n, ~vd_n}, 2'b01);   // R11 equalizing preset wins
    vs_pre_n = 1'b1;
    step(); step();
    check(9, {~svd_n, ~vd_n, ~vpb_n}, 3'b011); // R9 held at first eq half-line
    rst_n = 1'b0;
    step();
    check(1, obs, 10'b0);                // R1 reset mid-run
    eq_pre_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule